// File: doc/BRIEF.md
# Six-Source Interrupt Aggregator

This block merges six level-sensitive interrupt requests into a single host interrupt line. Each request passes through a per-source mask bit and a global enable gate; the host line is a registered signal that is high only while the global enable is on and at least one unmasked request is active. Software updates the mask through two write-one ports, one that sets bits and one that clears them, so a read-modify-write sequence is never needed.

The request sources sit at fixed bit positions: bit 0 first I2C channel, bit 1 second I2C channel, bit 2 SPI, bit 3 first DMA channel, bit 4 second DMA channel, bit 5 common-interface controller. When several unmasked requests are active, the lowest bit position wins. The index of that winner is given on a port and in a register so a handler can dispatch without scanning. Requests are cleared at their own blocks. This block only mirrors their live levels.

Register map, 8-bit byte address and 16-bit data: 0x40 status (bit 7 = host line), 0x44 live requests (bits 5:0), 0x4C winner (bits 2:0 index, bit 8 valid), 0x50 global enable (bit 7), 0x58 mask set, 0x5C mask clear. Reads return data one cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the host line is low, the mask reads 0x0000 and the enable register reads 0x0000.
- R2: A write to 0x58 sets every mask bit whose data bit is 1; mask bits whose data bit is 0 keep their value.
- R3: A write to 0x5C clears every mask bit whose data bit is 1 and leaves the others; writing 0xFFFF clears the whole mask.
- R4: The host line, one clock after any change, equals enable AND (any request bit AND its mask bit).
- R5: Writing 0x0000 to 0x50 drops the host line without losing the requests; writing 0x0080 raises it again while an unmasked request is still active.
- R6: Bit 7 of the status register at 0x40 reads as 1 exactly while the host line is high; the other bits read 0.
- R7: The register at 0x44 returns the live request levels in bits 5:0.
- R8: The winner index is the lowest bit position among active unmasked requests (0 = first I2C, 5 = common interface) and the valid flag is low when none is active.
- R9: Reads of 0x58 and of 0x5C both return the current mask.
- R10: The enable register reads back 0x0080 when enabled and 0x0000 when disabled.
- R11: Writes to the status, request and winner addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 6 | Live request levels, one bit per source |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |
| irq_out | output | 1 | Registered host interrupt line |
| win_idx | output | 3 | Index of the highest-priority active unmasked source |
| win_valid | output | 1 | High when any unmasked source is active |

## Verification
The main gate is tried with a single request and an empty mask, which separates the mask from the request path. A single matched request and mask shows the basic assertion. All six requests are then active while mask bits are removed one at a time, which walks the winner index through every priority position. Toggling the global enable with requests held shows that gating does not discard requests. Writes with sparse data to the set and clear ports, and writes to read-only addresses, show that untouched bits and read-only state stay as they were.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NSRC   = 6;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int EN_BIT = 7;
    localparam int ST_BIT = 7;
    localparam int WIN_VALID_BIT = 8;

    localparam logic [ADDR_W-1:0] A_STATUS  = 8'h40;
    localparam logic [ADDR_W-1:0] A_REQ     = 8'h44;
    localparam logic [ADDR_W-1:0] A_WINNER  = 8'h4C;
    localparam logic [ADDR_W-1:0] A_ENABLE  = 8'h50;
    localparam logic [ADDR_W-1:0] A_MSET    = 8'h58;
    localparam logic [ADDR_W-1:0] A_MCLR    = 8'h5C;

    typedef enum logic [IDX_W-1:0] {
        SRC_I2C_A = 3'd0,
        SRC_I2C_B = 3'd1,
        SRC_SPI   = 3'd2,
        SRC_DMA_A = 3'd3,
        SRC_DMA_B = 3'd4,
        SRC_CI    = 3'd5
    } src_e;

    typedef struct packed {
        logic            en;
        logic [NSRC-1:0] mask;
    } ctl_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } win_t;

    function automatic logic [DATA_W-1:0] pad_bit(input int pos, input logic v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[pos] = v;
        return r;
    endfunction

endpackage

// File: rtl/irq_agg_ctl.sv
module irq_agg_ctl
    import irq_agg_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              en,
    output logic [N-1:0]      mask
);

    logic [N-1:0] wbits;
    assign wbits = wdata[N-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            mask <= '0;
        end else if (we) begin
            case (addr)
                A_ENABLE: en   <= wdata[EN_BIT];
                A_MSET:   mask <= mask | wbits;
                A_MCLR:   mask <= mask & ~wbits;
                default:  ;
            endcase
        end
    end

    assert_mask_set_R2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_MSET) |=> ((mask & $past(wbits)) == $past(wbits)));

    assert_mask_keep_R2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_MSET) |=> ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));

    assert_mask_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_MCLR) |=> ((mask & $past(wbits)) == '0));

    assert_ro_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (we && (addr == A_STATUS || addr == A_REQ || addr == A_WINNER))
        |=> ($stable(mask) && $stable(en)));

endmodule

// File: rtl/irq_agg_prio.sv
module irq_agg_prio
    import irq_agg_pkg::*;
#(
    parameter int N = NSRC,
    localparam int IW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [IW-1:0] idx,
    output logic         valid
);

    logic [N-1:0] grant;
    logic [N:0]   seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end

    assign valid = seen[N];

    assert_grant_single_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_winner_lowest_R8: assert property (@(posedge clk) disable iff (rst)
        valid |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

    assert_none_R8: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> !valid);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int N = NSRC,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      src_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic [IW-1:0]     win_idx,
    output logic              win_valid
);

    ctl_t         ctl;
    logic [N-1:0] live_masked;
    win_t         win;

    irq_agg_ctl #(.N(N)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .en    (ctl.en),
        .mask  (ctl.mask)
    );

    assign live_masked = src_req & ctl.mask;

    irq_agg_prio #(.N(N)) u_prio (
        .clk   (clk),
        .rst   (rst),
        .req   (live_masked),
        .idx   (win.idx),
        .valid (win.valid)
    );

    assign win_idx   = win.idx;
    assign win_valid = win.valid;

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= ctl.en & win.valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                A_STATUS: bus_rdata <= pad_bit(ST_BIT, irq_out);
                A_REQ:    bus_rdata <= DATA_W'(src_req);
                A_WINNER: bus_rdata <= pad_bit(WIN_VALID_BIT, win.valid) | DATA_W'(win.idx);
                A_ENABLE: bus_rdata <= pad_bit(EN_BIT, ctl.en);
                A_MSET,
                A_MCLR:   bus_rdata <= DATA_W'(ctl.mask);
                default:  bus_rdata <= '0;
            endcase
        end
    end

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ($past(ctl.en) && $past(win.valid)));

    assert_irq_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && win.valid) |=> irq_out);

    assert_gate_off_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |=> !irq_out);

endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    import irq_agg_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  src_req;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic        bus_rd;
    logic [15:0] bus_rdata;
    logic        irq_out;
    logic [2:0]  win_idx;
    logic        win_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst(rst), .src_req(src_req),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .win_idx(win_idx), .win_valid(win_valid)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic set_req(input logic [5:0] r);
        @(negedge clk);
        src_req = r;
        @(negedge clk);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                #5;
                if (sb_q.size() == 0) begin
                    chk("scoreboard empty", 16'h0001, 16'h0000);
                end else begin
                    it = sb_q.pop_front();
                    chk(it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin : driver
        rst = 1'b1; src_req = '0; bus_addr = '0; bus_we = 1'b0;
        bus_wdata = '0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        chk("R1 irq after reset", 16'(irq_out), 16'h0);
        rd(A_MSET,   16'h0000, "R1 mask after reset");
        rd(A_ENABLE, 16'h0000, "R1/R10 enable after reset");

        wr(A_ENABLE, 16'h0080);
        rd(A_ENABLE, 16'h0080, "R10 enable readback");

        set_req(6'b001000);
        chk("R4 masked request keeps line low", 16'(irq_out), 16'h0);
        rd(A_REQ, 16'h0008, "R7 live request levels");

        wr(A_MSET, 16'h0008);
        settle();
        chk("R4 line rises on unmask", 16'(irq_out), 16'h1);
        rd(A_MSET, 16'h0008, "R9 mask via set address");
        rd(A_MCLR, 16'h0008, "R9 mask via clear address");
        rd(A_STATUS, 16'h0080, "R6 status high");
        chk("R8 winner is DMA A", {12'h0, win_valid, win_idx}, 16'h000B);
        rd(A_WINNER, 16'h0103, "R8 winner register");

        wr(A_MSET, 16'h0001);
        rd(A_MSET, 16'h0009, "R2 zero bits keep mask");

        wr(A_MSET, 16'h003F);
        set_req(6'b111111);
        rd(A_MCLR, 16'h003F, "R2 full set");
        for (int k = 0; k < 6; k++) begin
            chk($sformatf("R8 priority walk step %0d", k),
                {12'h0, win_valid, win_idx}, 16'(4'h8 | k));
            wr(A_MCLR, 16'(1 << k));
        end
        chk("R8 no winner when all masked", 16'(win_valid), 16'h0);
        settle();
        chk("R4 line low with empty mask", 16'(irq_out), 16'h0);

        wr(A_MSET, 16'h003F);
        settle();
        chk("R4 line high with all sources", 16'(irq_out), 16'h1);
        wr(A_ENABLE, 16'h0000);
        settle();
        chk("R5 disable drops line", 16'(irq_out), 16'h0);
        rd(A_REQ, 16'h003F, "R5 requests kept while disabled");
        rd(A_STATUS, 16'h0000, "R6 status low while disabled");
        rd(A_ENABLE, 16'h0000, "R10 enable reads zero");
        wr(A_ENABLE, 16'h0080);
        settle();
        chk("R5 re-enable raises line", 16'(irq_out), 16'h1);

        wr(A_MCLR, 16'h0002);
        rd(A_MSET, 16'h003D, "R3 zero bits keep mask");
        wr(A_STATUS, 16'hFFFF);
        wr(A_REQ, 16'h0000);
        wr(A_WINNER, 16'hFFFF);
        rd(A_MSET, 16'h003D, "R11 read-only writes leave mask");
        rd(A_ENABLE, 16'h0080, "R11 read-only writes leave enable");
        rd(A_REQ, 16'h003F, "R11 request register still live");

        set_req(6'b000000);
        chk("R4 line falls when requests drop", 16'(irq_out), 16'h0);
        chk("R8 valid low with no requests", 16'(win_valid), 16'h0);
        set_req(6'b100000);
        chk("R8 winner is common interface", {12'h0, win_valid, win_idx}, 16'h000D);

        wr(A_MCLR, 16'hFFFF);
        rd(A_MCLR, 16'h0000, "R3 clear all");
        settle();
        chk("R3 line low after clear all", 16'(irq_out), 16'h0);

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) chk("R1 scoreboard drained", 16'(sb_q.size()), 16'h0);
        finish_run();
    end

endmodule